// File: doc/BRIEF.md
# Dual-Axis Quadrature Pointer Counter

This block turns the two-phase A/B signals of a pointing device (mouse or trackball) into a pair of position counts. Each axis has its own synchronizer, edge decoder and up/down counter. Every edge of either phase counts once, so one full encoder cycle gives four counts. Whether a count goes up or down depends on which phase leads.

A host reads a count over one byte-wide output in two accesses. It first reads the low byte and then the high byte, choosing the axis and the byte with plain select lines. The low-byte read also captures the whole count of the chosen axis. The high-byte read that follows returns bits from that capture, so a count that moves between the two accesses cannot tear the value. The high byte also carries the states of the three push buttons. Two status outputs tell the host when a count has moved and when a button is held.

Top module: `twin_axis_counter`

## Requirements
- R1: An axis counts up by one on each single-phase change in the order {A,B} = 00→10→11→01→00 (A leads B).
- R2: An axis counts down by one on each single-phase change in the reverse order 00→01→11→10→00 (B leads A).
- R3: When A and B of an axis both change between two samples, that axis count stays unchanged.
- R4: Counts are 12 bits and wrap modulo 4096 in both directions (0 − 1 = 0xFFF, 0xFFF + 1 = 0).
- R5: `rst_n` low clears both counts to 0x000, and `dout` and `cnt_flag` to zero. A one-cycle `clr_x` / `clr_y` pulse clears only its own axis to 0x000 and leaves the other axis unchanged.
- R6: A strobe with `rd_en`=1 and `hi_sel`=0 loads `dout` with count bits 7:0 of the axis chosen by `axis_sel` (0 = X, 1 = Y). The same strobe captures that axis's full count.
- R7: A strobe with `hi_sel`=1 loads `dout` = {0, middle, left, right, captured count bits 11:8}. Each key bit is 1 while its button is pressed. The count bits come from the last low-byte capture of that axis, even if the live count has moved since.
- R8: `dout` holds its value while `rd_en` is low.
- R9: `cnt_flag` goes to 1 after any count step on either axis and is cleared by any read strobe. A step in the same cycle as a read wins, so the flag stays set.
- R10: `key_n` is active low, with bit 0 = right, bit 1 = left and bit 2 = middle. `key_flag` is 1 while any key is pressed, two clock edges after the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_x | input | 1 | Synchronous clear of the X count |
| clr_y | input | 1 | Synchronous clear of the Y count |
| xa | input | 1 | X axis phase A |
| xb | input | 1 | X axis phase B |
| ya | input | 1 | Y axis phase A |
| yb | input | 1 | Y axis phase B |
| key_n | input | 3 | Buttons, active low: [0] right, [1] left, [2] middle |
| rd_en | input | 1 | Read strobe (chip select) |
| axis_sel | input | 1 | 0 = X, 1 = Y |
| hi_sel | input | 1 | 0 = low byte, 1 = high byte |
| dout | output | 8 | Registered read data |
| cnt_flag | output | 1 | A count has moved since the last read |
| key_flag | output | 1 | A button is pressed |

## Verification
A phase change at the pins shows in the count on the third rising edge: two synchronizer stages and then the counter register. `cnt_flag` rises on that same edge. A key change reaches `key_flag` after two edges. `dout` changes on the edge that samples the read strobe. The bench drives every input on a falling edge and waits four full cycles after each encoder or key change before it looks. It reads `dout` on the falling edge right after the strobe edge, so every sample falls after the result is due and before the next stimulus.

// File: rtl/tac_pkg.sv
package tac_pkg;
  typedef enum logic [1:0] {STEP_NONE, STEP_UP, STEP_DN, STEP_BAD} step_e;

  // prv/cur are {A,B}; one bit changing is a legal step
  function automatic step_e classify(input logic [1:0] prv, input logic [1:0] cur);
    if (prv == cur) return STEP_NONE;
    if ((prv ^ cur) == 2'b11) return STEP_BAD;
    return (cur[1] ^ prv[0]) ? STEP_UP : STEP_DN;
  endfunction
endpackage

// File: rtl/tac_sync.sv
module tac_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= RV;
      q  <= RV;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/tac_axis.sv
module tac_axis
  import tac_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          a,
  input  logic          b,
  output logic [CW-1:0] count,
  output logic          step_evt,
  output logic          bad_evt
);
  localparam logic [CW-1:0] ONE = 1;
  logic [1:0] prv;
  step_e      st;

  assign st       = classify(prv, {a, b});
  assign step_evt = (st == STEP_UP || st == STEP_DN) && !clr;
  assign bad_evt  = (st == STEP_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv   <= 2'b00;
      count <= '0;
    end else begin
      prv <= {a, b};
      if (clr) count <= '0;
      else if (st == STEP_UP) count <= count + ONE;
      else if (st == STEP_DN) count <= count - ONE;
    end
  end

  AST_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STEP_UP && !clr) |=> count == $past(count) + ONE); // R1
  AST_DN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == STEP_DN && !clr) |=> count == $past(count) - ONE); // R2
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_evt && !clr) |=> $stable(count)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R5
endmodule

// File: rtl/twin_axis_counter.sv
module twin_axis_counter #(
  parameter int CW = 12,
  parameter int DW = 8,
  parameter int NK = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_x,
  input  logic          clr_y,
  input  logic          xa,
  input  logic          xb,
  input  logic          ya,
  input  logic          yb,
  input  logic [NK-1:0] key_n,
  input  logic          rd_en,
  input  logic          axis_sel,
  input  logic          hi_sel,
  output logic [DW-1:0] dout,
  output logic          cnt_flag,
  output logic          key_flag
);
  localparam int HW = CW - DW;
  localparam int PW = DW - HW - NK;

  logic [3:0]    enc_s;
  logic [NK-1:0] key_s;
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] snap [2];
  logic [1:0]    step_evt, bad_evt;
  logic [1:0]    clr_v;
  logic          any_step;
  logic [NK-1:0] pressed;

  tac_sync #(.W(4), .RV(4'b0000)) u_enc_sync (
    .clk(clk), .rst_n(rst_n), .d({ya, yb, xa, xb}), .q(enc_s));
  tac_sync #(.W(NK), .RV({NK{1'b1}})) u_key_sync (
    .clk(clk), .rst_n(rst_n), .d(key_n), .q(key_s));

  assign clr_v = {clr_y, clr_x};

  for (genvar g = 0; g < 2; g++) begin : g_axis
    tac_axis #(.CW(CW)) u_axis (
      .clk(clk), .rst_n(rst_n), .clr(clr_v[g]),
      .a(enc_s[2*g+1]), .b(enc_s[2*g]),
      .count(cnt[g]), .step_evt(step_evt[g]), .bad_evt(bad_evt[g]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) snap[g] <= '0;
      else if (rd_en && !hi_sel && (axis_sel == g[0])) snap[g] <= cnt[g];
    end
  end

  assign any_step = |step_evt;
  assign pressed  = ~key_s;
  assign key_flag = |pressed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      cnt_flag <= 1'b0;
    end else begin
      if (rd_en) begin
        if (hi_sel) dout <= {{PW{1'b0}}, pressed, snap[axis_sel][CW-1:DW]};
        else        dout <= cnt[axis_sel][DW-1:0];
      end
      if (any_step)   cnt_flag <= 1'b1;
      else if (rd_en) cnt_flag <= 1'b0;
    end
  end

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(dout)); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any_step |=> cnt_flag); // R9
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_step) |=> !cnt_flag); // R9
  AST_LO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hi_sel) |=> dout == $past(cnt[axis_sel][DW-1:0])); // R6
endmodule

// File: tb/sim_twin_axis_counter.sv
`timescale 1ns/1ps
module sim_twin_axis_counter;
  logic clk = 1'b0;
  logic rst_n, clr_x, clr_y, xa, xb, ya, yb, rd_en, axis_sel, hi_sel;
  logic [2:0] key_n;
  logic [7:0] dout;
  logic cnt_flag, key_flag;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twin_axis_counter u0 (
    .clk(clk), .rst_n(rst_n), .clr_x(clr_x), .clr_y(clr_y),
    .xa(xa), .xb(xb), .ya(ya), .yb(yb), .key_n(key_n),
    .rd_en(rd_en), .axis_sel(axis_sel), .hi_sel(hi_sel),
    .dout(dout), .cnt_flag(cnt_flag), .key_flag(key_flag));

  // {a, b, expected flag, expected 12-bit X count}
  localparam logic [14:0] VEC [13] = '{
    {2'b10, 1'b1, 12'd1},   {2'b11, 1'b1, 12'd2},   {2'b01, 1'b1, 12'd3},
    {2'b00, 1'b1, 12'd4},   {2'b01, 1'b1, 12'd3},   {2'b11, 1'b1, 12'd2},
    {2'b10, 1'b1, 12'd1},   {2'b00, 1'b1, 12'd0},   {2'b11, 1'b0, 12'd0},
    {2'b10, 1'b1, 12'hFFF}, {2'b11, 1'b1, 12'h000}, {2'b10, 1'b1, 12'hFFF},
    {2'b00, 1'b1, 12'hFFE}};

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic ax, input logic hi, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; axis_sel = ax; hi_sel = hi;
    @(negedge clk);
    rd_en = 1'b0;
    v = dout;
  endtask

  task automatic rd12(input logic ax, output logic [11:0] c, output logic [2:0] k);
    logic [7:0] lo, hi;
    rd(ax, 1'b0, lo);
    rd(ax, 1'b1, hi);
    c = {hi[3:0], lo};
    k = hi[6:4];
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] c;
    logic [2:0] k;
    logic [7:0] v, hold;
    rst_n = 0; clr_x = 0; clr_y = 0; xa = 0; xb = 0; ya = 0; yb = 0;
    key_n = 3'b111; rd_en = 0; axis_sel = 0; hi_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R5 reset dout", dout, 0);
    chk("R5 reset cnt_flag", cnt_flag, 0);
    chk("R10 idle key_flag", key_flag, 0);
    rd12(1'b0, c, k);
    chk("R5 reset X count", c, 0);

    // table walk: R1/R2/R3/R4 sequences on X
    for (int i = 0; i < 13; i++) begin
      @(negedge clk);
      {xa, xb} = VEC[i][14:13];
      settle();
      chk($sformatf("R9 flag vec%0d", i), cnt_flag, VEC[i][12]);
      rd12(1'b0, c, k);
      chk($sformatf("R1/R2/R3/R4 count vec%0d", i), c, VEC[i][11:0]);
      chk("R9 flag cleared by read", cnt_flag, 0);
    end

    // R7 snapshot coherency across a wrap: X = 0xFFE, state 00
    @(negedge clk); {xa, xb} = 2'b10; settle();
    rd(1'b0, 1'b0, v);
    chk("R6 low byte", v, 8'hFF);
    @(negedge clk); {xa, xb} = 2'b11; settle();
    rd(1'b0, 1'b1, v);
    chk("R7 high byte from snapshot", v, 8'h0F);
    rd(1'b0, 1'b0, v);
    chk("R6 live low after wrap R4", v, 8'h00);

    // R8 dout holds without strobe
    hold = dout;
    @(negedge clk); {xa, xb} = 2'b01; settle();
    chk("R8 dout hold", dout, hold);

    // R10 keys
    @(negedge clk); key_n = 3'b110; settle();
    chk("R10 key_flag right", key_flag, 1);
    rd(1'b0, 1'b1, v);
    chk("R7 right key bit", v, 8'h10);
    @(negedge clk); key_n = 3'b011; settle();
    rd(1'b1, 1'b1, v);
    chk("R7 middle key bit on Y", v, 8'h40);
    @(negedge clk); key_n = 3'b101; settle();
    rd(1'b1, 1'b1, v);
    chk("R7 left key bit", v, 8'h20);
    @(negedge clk); key_n = 3'b111; settle();
    chk("R10 key_flag released", key_flag, 0);

    // Y counts, then X-only clear
    @(negedge clk); {ya, yb} = 2'b10; settle();
    @(negedge clk); {ya, yb} = 2'b11; settle();
    @(negedge clk); {ya, yb} = 2'b01; settle();
    rd12(1'b1, c, k);
    chk("R1 Y counts up", c, 3);
    @(negedge clk); {ya, yb} = 2'b11; settle();
    rd12(1'b1, c, k);
    chk("R2 Y counts down", c, 2);
    @(negedge clk); {xa, xb} = 2'b00; settle();
    rd12(1'b0, c, k);
    chk("R1 X before clear", c, 2);
    @(negedge clk); clr_x = 1;
    @(negedge clk); clr_x = 0;
    rd12(1'b0, c, k);
    chk("R5 X cleared", c, 0);
    rd12(1'b1, c, k);
    chk("R5 Y unaffected", c, 2);
    @(negedge clk); clr_y = 1;
    @(negedge clk); clr_y = 0;
    rd12(1'b1, c, k);
    chk("R5 Y cleared", c, 0);

    // R3 illegal jump on Y
    @(negedge clk); {ya, yb} = 2'b00; settle();
    rd12(1'b1, c, k);
    chk("R3 Y illegal hold", c, 0);
    chk("R9 no flag on illegal", cnt_flag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule